// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This combinational block sits in front of the arithmetic datapath of a single-precision fused multiply-add unit. Each cycle it takes three binary32 operands: the addend `op_z` and the two factors `op_x` and `op_y`. It also takes a flag that turns the operation into `z - x*y`, and the current rounding mode. It sorts every operand into zero, subnormal, normal, infinity, quiet NaN or signalling NaN. From those classes it decides whether the result is already fixed by the operand classes alone.

When the result is fixed, the block drives the final 32-bit word on `result` and raises `special`. It also flags an invalid operation where one occurs. When the result is not fixed, it raises `compute` instead, and the multiplier, aligner, adder and rounder behind it produce the number. Subnormal operands count as finite and nonzero here. Normalising them is left to the datapath.

Top module: `fma_special_resolve`

## Requirements
- R1: For every input combination exactly one of `special` and `compute` is 1.
- R2: A signalling NaN (exponent all ones, fraction bit 22 clear, fraction nonzero) outranks every other operand, checking `op_z`, then `op_x`, then `op_y`. The result is that operand with fraction bit 22 set, and `invalid` is 1.
- R3: With no signalling NaN present, the first quiet NaN (exponent all ones, fraction bit 22 set) found in the order `op_z`, `op_x`, `op_y` is returned bit for bit, with `invalid` 0.
- R4: If one factor is infinite and the other is zero, the result is the default NaN 32'h7FC00000 and `invalid` is 1.
- R5: The effective product sign is `op_x[31] ^ op_y[31] ^ neg_prod`. It governs every rule below that mentions the product sign.
- R6: If the product is infinite and `op_z` is an infinity whose sign differs from the effective product sign, the result is the default NaN and `invalid` is 1.
- R7: In every other case with an infinite product, the result is an infinity with the effective product sign (32'h7F800000 or 32'hFF800000), with `invalid` 0.
- R8: If the product is zero and `op_z` is an infinity, a nonzero normal or a subnormal, the result is `op_z` unchanged.
- R9: If the product is zero and `op_z` is a zero with the effective product sign, the result is `op_z`.
- R10: If the product is zero and `op_z` is a zero of the other sign, the result is +0. It is -0 when `rnd_mode` is 2'b11 (round toward minus infinity).
- R11: If the product is finite and nonzero and `op_z` is an infinity, the result is `op_z`.
- R12: If both the product and `op_z` are finite, nonzero and non-NaN, `compute` is 1, `result` is 0 and `invalid` is 0.
- R13: `invalid` is never 1 while `special` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_z | input | 32 | Addend operand |
| op_x | input | 32 | First factor |
| op_y | input | 32 | Second factor |
| neg_prod | input | 1 | 1 selects `z - x*y` |
| rnd_mode | input | 2 | Rounding mode, 2'b11 = toward minus infinity |
| result | output | 32 | Final result when `special` is 1, else 0 |
| invalid | output | 1 | Invalid-operation flag |
| special | output | 1 | Result is fully determined here |
| compute | output | 1 | Datapath must produce the result |

## Verification
The bench aims at NaN precedence when several NaNs of both kinds occur together. A design that checked the kinds in the wrong order would return a quiet NaN while a signalling one was present. A design that dropped the quieting bit would hand a signalling NaN downstream.

The bench also covers opposite-signed infinities and exact zero sums, toggling `neg_prod` in both. A product sign that ignored the subtract flag would show up as a spurious invalid, or as the wrong sign on an infinity. An exact zero sum that ignored the rounding mode would give +0 where -0 is due.

Subnormal factors and addends also receive a share of the stimulus. A classifier that treated them as zero would return `op_z`, or skip the datapath, where `compute` is required.

// File: rtl/fmasr_pkg.sv
package fmasr_pkg;

   typedef enum logic [2:0] {
      CL_ZERO = 3'd0,
      CL_SUB  = 3'd1,
      CL_NORM = 3'd2,
      CL_INF  = 3'd3,
      CL_QNAN = 3'd4,
      CL_SNAN = 3'd5
   } opclass_t;

   localparam int unsigned NUM_OPS = 3;
   localparam int unsigned IDX_Z   = 0;
   localparam int unsigned IDX_X   = 1;
   localparam int unsigned IDX_Y   = 2;

endpackage

// File: rtl/fmasr_classify.sv
module fmasr_classify
   import fmasr_pkg::*;
#(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23,
   localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] operand,
   output opclass_t     cls,
   output logic         sgn
);

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_max;
   logic              exp_min;
   logic              frac_nz;

   assign sgn     = operand[W-1];
   assign exp_f   = operand[W-2 -: EXP_W];
   assign frac_f  = operand[FRAC_W-1:0];
   assign exp_max = &exp_f;
   assign exp_min = ~|exp_f;
   assign frac_nz = |frac_f;

   always_comb begin
      if (exp_max) begin
         if (!frac_nz)                 cls = CL_INF;
         else if (frac_f[FRAC_W-1])    cls = CL_QNAN;
         else                          cls = CL_SNAN;
      end else if (exp_min) begin
         cls = frac_nz ? CL_SUB : CL_ZERO;
      end else begin
         cls = CL_NORM;
      end
   end

endmodule

// File: rtl/fmasr_nan_pick.sv
module fmasr_nan_pick
   import fmasr_pkg::*;
#(
   parameter int unsigned W          = 32,
   parameter int unsigned FRAC_W     = 23,
   parameter int unsigned N          = 3,
   parameter bit          QUIET_SNAN = 1'b1
) (
   input  logic [W-1:0] ops [N],
   input  opclass_t     cls [N],
   output logic         hit,
   output logic         sig,
   output logic [W-1:0] value
);

   logic [W-1:0] quiet_mask;

   generate
      if (QUIET_SNAN) begin : g_quiet
         assign quiet_mask = W'(1) << (FRAC_W - 1);
      end else begin : g_pass
         assign quiet_mask = '0;
      end
   endgenerate

   // Lowest index has highest priority; signalling pass overrides quiet pass.
   always_comb begin
      hit   = 1'b0;
      sig   = 1'b0;
      value = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (cls[i] == CL_QNAN) begin
            hit   = 1'b1;
            value = ops[i];
         end
      end
      for (int i = N - 1; i >= 0; i--) begin
         if (cls[i] == CL_SNAN) begin
            hit   = 1'b1;
            sig   = 1'b1;
            value = ops[i] | quiet_mask;
         end
      end
   end

endmodule

// File: rtl/fmasr_finite_rules.sv
module fmasr_finite_rules
   import fmasr_pkg::*;
#(
   parameter int unsigned           EXP_W       = 8,
   parameter int unsigned           FRAC_W      = 23,
   localparam int unsigned          W           = 1 + EXP_W + FRAC_W,
   parameter logic [W-1:0]          DEFAULT_NAN = 32'h7FC0_0000
) (
   input  opclass_t     cls_z,
   input  opclass_t     cls_x,
   input  opclass_t     cls_y,
   input  logic         sgn_z,
   input  logic         sgn_x,
   input  logic         sgn_y,
   input  logic         neg_prod,
   input  logic         rnd_down,
   input  logic [W-1:0] op_z,
   output logic         special,
   output logic         invalid,
   output logic [W-1:0] result
);

   logic eff_s;
   logic x_zero, y_zero, x_inf, y_inf, z_inf, z_zero;
   logic inf_times_zero, prod_inf, prod_zero;

   assign eff_s  = sgn_x ^ sgn_y ^ neg_prod;
   assign x_zero = (cls_x == CL_ZERO);
   assign y_zero = (cls_y == CL_ZERO);
   assign x_inf  = (cls_x == CL_INF);
   assign y_inf  = (cls_y == CL_INF);
   assign z_inf  = (cls_z == CL_INF);
   assign z_zero = (cls_z == CL_ZERO);

   assign inf_times_zero = (x_inf & y_zero) | (x_zero & y_inf);
   assign prod_inf       = (x_inf | y_inf) & ~inf_times_zero;
   assign prod_zero      = (x_zero | y_zero) & ~inf_times_zero;

   always_comb begin
      special = 1'b1;
      invalid = 1'b0;
      result  = '0;
      if (inf_times_zero) begin
         invalid = 1'b1;
         result  = DEFAULT_NAN;
      end else if (prod_inf) begin
         if (z_inf && (sgn_z != eff_s)) begin
            invalid = 1'b1;
            result  = DEFAULT_NAN;
         end else begin
            result  = {eff_s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
         end
      end else if (prod_zero) begin
         if (z_zero && (sgn_z != eff_s))
            result = {rnd_down, {(W-1){1'b0}}};
         else
            result = op_z;
      end else if (z_inf) begin
         result = op_z;
      end else begin
         special = 1'b0;
      end
   end

endmodule

// File: rtl/fma_special_resolve.sv
module fma_special_resolve
   import fmasr_pkg::*;
#(
   parameter int unsigned     EXP_W       = 8,
   parameter int unsigned     FRAC_W      = 23,
   parameter int unsigned     RM_W        = 2,
   parameter logic [RM_W-1:0] RM_DOWN     = 2'b11,
   parameter logic [EXP_W+FRAC_W:0] DEFAULT_NAN = 32'h7FC0_0000,
   parameter bit              QUIET_SNAN  = 1'b1
) (
   input  logic [EXP_W+FRAC_W:0] op_z,
   input  logic [EXP_W+FRAC_W:0] op_x,
   input  logic [EXP_W+FRAC_W:0] op_y,
   input  logic                  neg_prod,
   input  logic [RM_W-1:0]       rnd_mode,
   output logic [EXP_W+FRAC_W:0] result,
   output logic                  invalid,
   output logic                  special,
   output logic                  compute
);

   localparam int unsigned W = 1 + EXP_W + FRAC_W;

   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("EXP_W must be at least 2");
      end
      if (FRAC_W < 2) begin : g_bad_frac
         $error("FRAC_W must be at least 2");
      end
      if (!(&DEFAULT_NAN[W-2 -: EXP_W]) || !DEFAULT_NAN[FRAC_W-1]) begin : g_bad_nan
         $error("DEFAULT_NAN must encode a quiet NaN");
      end
   endgenerate

   logic [W-1:0] ops [NUM_OPS];
   opclass_t     cls [NUM_OPS];
   logic         sgn [NUM_OPS];

   assign ops[IDX_Z] = op_z;
   assign ops[IDX_X] = op_x;
   assign ops[IDX_Y] = op_y;

   generate
      for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
         fmasr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .operand (ops[g]),
            .cls     (cls[g]),
            .sgn     (sgn[g])
         );
      end
   endgenerate

   logic         nan_hit, nan_sig;
   logic [W-1:0] nan_val;

   fmasr_nan_pick #(
      .W(W), .FRAC_W(FRAC_W), .N(NUM_OPS), .QUIET_SNAN(QUIET_SNAN)
   ) u_nan (
      .ops   (ops),
      .cls   (cls),
      .hit   (nan_hit),
      .sig   (nan_sig),
      .value (nan_val)
   );

   logic         fin_special, fin_invalid;
   logic [W-1:0] fin_result;

   fmasr_finite_rules #(
      .EXP_W(EXP_W), .FRAC_W(FRAC_W), .DEFAULT_NAN(DEFAULT_NAN)
   ) u_fin (
      .cls_z    (cls[IDX_Z]),
      .cls_x    (cls[IDX_X]),
      .cls_y    (cls[IDX_Y]),
      .sgn_z    (sgn[IDX_Z]),
      .sgn_x    (sgn[IDX_X]),
      .sgn_y    (sgn[IDX_Y]),
      .neg_prod (neg_prod),
      .rnd_down (rnd_mode == RM_DOWN),
      .op_z     (op_z),
      .special  (fin_special),
      .invalid  (fin_invalid),
      .result   (fin_result)
   );

   always_comb begin
      if (nan_hit) begin
         result  = nan_val;
         invalid = nan_sig;
         special = 1'b1;
      end else begin
         result  = fin_result;
         invalid = fin_invalid;
         special = fin_special;
      end
      compute = ~special;
   end

endmodule

// File: rtl/fma_special_resolve_chk.sv
module fma_special_resolve_chk #(
   parameter int unsigned W           = 32,
   parameter int unsigned FRAC_W      = 23,
   parameter logic [W-1:0] DEFAULT_NAN = 32'h7FC0_0000
) (
   input logic [W-1:0] op_z,
   input logic [W-1:0] op_x,
   input logic [W-1:0] op_y,
   input logic [W-1:0] result,
   input logic         invalid,
   input logic         special,
   input logic         compute
);

   localparam int unsigned EXP_W = W - 1 - FRAC_W;

   function automatic logic is_snan(input logic [W-1:0] v);
      return (&v[W-2 -: EXP_W]) && !v[FRAC_W-1] && (|v[FRAC_W-2:0]);
   endfunction

   function automatic logic is_qnan(input logic [W-1:0] v);
      return (&v[W-2 -: EXP_W]) && v[FRAC_W-1];
   endfunction

   logic any_snan;
   assign any_snan = is_snan(op_z) || is_snan(op_x) || is_snan(op_y);

   always_comb begin
      a_r1_exclusive: assert (special != compute)
         else $error("special and compute not exclusive");
      a_r13_invalid_special: assert (!invalid || special)
         else $error("invalid without special");
      a_r12_compute_quiet: assert (!compute || (result == '0 && !invalid))
         else $error("compute with nonzero result or flag");
      a_r2_snan_flags: assert (!any_snan || (invalid && result[FRAC_W-1]))
         else $error("signalling NaN not flagged or not quieted");
      a_r3_qnan_z_first: assert (any_snan || !is_qnan(op_z) || (result == op_z && !invalid))
         else $error("quiet NaN addend not returned");
      a_r4_indef: assert (!invalid || any_snan || result == DEFAULT_NAN)
         else $error("invalid without default NaN");
   end

endmodule

bind fma_special_resolve fma_special_resolve_chk #(
   .W(EXP_W + FRAC_W + 1), .FRAC_W(FRAC_W), .DEFAULT_NAN(DEFAULT_NAN)
) u_chk (
   .op_z    (op_z),
   .op_x    (op_x),
   .op_y    (op_y),
   .result  (result),
   .invalid (invalid),
   .special (special),
   .compute (compute)
);

// File: tb/fma_special_resolve_tb.sv
module fma_special_resolve_tb;

   logic        clk = 1'b0;
   logic [31:0] op_z, op_x, op_y;
   logic        neg_prod;
   logic [1:0]  rnd_mode;
   logic [31:0] result;
   logic        invalid, special, compute;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   fma_special_resolve u_dut (
      .op_z(op_z), .op_x(op_x), .op_y(op_y),
      .neg_prod(neg_prod), .rnd_mode(rnd_mode),
      .result(result), .invalid(invalid), .special(special), .compute(compute)
   );

   // 0 zero, 1 sub, 2 norm, 3 inf, 4 qnan, 5 snan
   function automatic int kind(input logic [31:0] v);
      if (v[30:23] == 8'hFF) begin
         if (v[22:0] == 0) return 3;
         return v[22] ? 4 : 5;
      end
      if (v[30:23] == 0) return (v[22:0] == 0) ? 0 : 1;
      return 2;
   endfunction

   function automatic logic [31:0] make_op(input int k);
      logic       s;
      logic [22:0] f;
      logic [7:0]  e;
      s = 1'($urandom);
      f = 23'($urandom);
      e = 8'($urandom_range(1, 254));
      case (k)
         0: return {s, 31'd0};
         1: return {s, 8'd0, f | 23'd1};
         2: return {s, e, f};
         3: return {s, 8'hFF, 23'd0};
         4: return {s, 8'hFF, 1'b1, f[21:0]};
         default: return {s, 8'hFF, 1'b0, f[21:0] | 22'd1};
      endcase
   endfunction

   task automatic model(input logic [31:0] z, x, y, input logic ng, input logic [1:0] rm,
                        output logic [31:0] r, output logic sp, output logic inv,
                        output string tag);
      int kz, kx, ky;
      logic es;
      kz = kind(z); kx = kind(x); ky = kind(y);
      es = x[31] ^ y[31] ^ ng;   // R5
      sp = 1'b1; inv = 1'b0; r = 32'd0;
      if (kz == 5)      begin r = z | 32'h0040_0000; inv = 1; tag = "R2"; end
      else if (kx == 5) begin r = x | 32'h0040_0000; inv = 1; tag = "R2"; end
      else if (ky == 5) begin r = y | 32'h0040_0000; inv = 1; tag = "R2"; end
      else if (kz == 4) begin r = z; tag = "R3"; end
      else if (kx == 4) begin r = x; tag = "R3"; end
      else if (ky == 4) begin r = y; tag = "R3"; end
      else if ((kx == 3 && ky == 0) || (kx == 0 && ky == 3)) begin
         r = 32'h7FC0_0000; inv = 1; tag = "R4";
      end else if (kx == 3 || ky == 3) begin
         if (kz == 3 && z[31] != es) begin r = 32'h7FC0_0000; inv = 1; tag = "R6"; end
         else begin r = {es, 8'hFF, 23'd0}; tag = "R5,R7"; end
      end else if (kx == 0 || ky == 0) begin
         if (kz == 0 && z[31] != es) begin r = {rm == 2'b11, 31'd0}; tag = "R10"; end
         else if (kz == 0) begin r = z; tag = "R9"; end
         else begin r = z; tag = "R8"; end
      end else if (kz == 3) begin
         r = z; tag = "R11";
      end else begin
         sp = 1'b0; tag = "R12";
      end
   endtask

   task automatic run_vec(input logic [31:0] z, x, y, input logic ng, input logic [1:0] rm);
      logic [31:0] er;
      logic        esp, einv;
      string       tag;
      model(z, x, y, ng, rm, er, esp, einv, tag);
      @(negedge clk);
      op_z = z; op_x = x; op_y = y; neg_prod = ng; rnd_mode = rm;
      #1;
      checks++;
      // R1 and R13 are checked on every vector alongside the case tag
      if (result !== er || special !== esp || invalid !== einv || compute !== !esp) begin
         failures++;
         $display("FAIL %s/R1/R13 z=%h x=%h y=%h neg=%0b rm=%0d: got r=%h sp=%0b inv=%0b cmp=%0b exp r=%h sp=%0b inv=%0b cmp=%0b",
                  tag, z, x, y, ng, rm, result, special, invalid, compute,
                  er, esp, einv, !esp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7719));
      op_z = '0; op_x = '0; op_y = '0; neg_prod = 0; rnd_mode = '0;
      @(posedge clk);
      // initial all-zero state: R9 (+0 + +0*+0 = +0)
      run_vec(32'h0, 32'h0, 32'h0, 0, 2'b00);
      // R2: snan precedence, z over x, then x over y, snan over qnan
      run_vec(32'h7FC1_0000, 32'h7F80_0001, 32'hFF80_0002, 0, 0);
      run_vec(32'h3F80_0000, 32'h7F80_0005, 32'hFF80_0002, 0, 0);
      run_vec(32'h7F80_0003, 32'h7FC0_0000, 32'h7F80_0002, 0, 0);
      // R3: qnan order z, x, y
      run_vec(32'h3F80_0000, 32'hFFC0_1234, 32'h7FC0_0001, 0, 0);
      run_vec(32'h7FE0_0000, 32'hFFC0_1234, 32'h7FC0_0001, 1, 3);
      // R4: inf*0
      run_vec(32'h3F80_0000, 32'hFF80_0000, 32'h8000_0000, 0, 0);
      // R6 / R7 with negate flag flipping the product sign (R5)
      run_vec(32'hFF80_0000, 32'h7F80_0000, 32'h3F80_0000, 0, 0);
      run_vec(32'hFF80_0000, 32'h7F80_0000, 32'h3F80_0000, 1, 0);
      run_vec(32'h7F80_0000, 32'h7F80_0000, 32'h7F80_0000, 1, 0);
      // R10: +0 + (-0) under both rounding modes; R9 via negate
      run_vec(32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 0, 0);
      run_vec(32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 0, 3);
      run_vec(32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 1, 3);
      // R8: subnormal addend with zero product; R11 / R12 subnormal factors
      run_vec(32'h8000_0001, 32'h0000_0000, 32'h0000_0007, 0, 3);
      run_vec(32'hFF80_0000, 32'h0000_0001, 32'h0000_0002, 0, 0);
      run_vec(32'h0000_0001, 32'h0000_0001, 32'h3F80_0000, 0, 0);
      for (int i = 0; i < 4000; i++) begin
         run_vec(make_op($urandom_range(0, 5)), make_op($urandom_range(0, 5)),
                 make_op($urandom_range(0, 5)), 1'($urandom), 2'($urandom));
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule